// File: doc/BRIEF.md
# Keystream Sequencer

This block turns a 128-bit key and a 128-bit initialization value into a stream of 32-bit keystream words. It holds a sixteen-word shift register with a nonlinear feedback made of byte-wise multiplication by a field constant and its inverse. A three-register mixing machine built from two 32-bit substitution boxes feeds it. A single start request loads both from the key and IV and runs the warm-up. The block then produces as many words as the caller asked for, one per clock, each marked by a valid strobe.

A client drives key, iv and the word count, pulses start for one cycle while the block is idle, and collects `ks_word` on every cycle where `ks_valid` is high. `done` marks the end of the request. Combining the keystream with data is left to the client.

Top module: `keystream_seq`

## Requirements
- R1: After synchronous reset `busy`, `done` and `ks_valid` are low and `ks_word` is zero.
- R2: Key word k_i is `key[32*i+31:32*i]` and IV word v_i is `iv[32*i+31:32*i]`. An accepted start clears the three mixer registers and loads the cells. The low quarter (cells 0..3) gets ~k0..~k3, cells 4..7 get k0..k3, cells 8..11 get ~k0..~k3 and cells 12..15 get k0..k3. Cell 15 is then XORed with v0, cell 12 with v1, cell 10 with v2 and cell 9 with v3.
- R3: After acceptance exactly 32 warm-up rounds run, each feeding the mixer output into the shift register feedback. One more step follows whose mixer output is thrown away. The first word is valid after the 35th rising edge, counting the accepting edge as the first.
- R4: Each word equals the mixer output F XOR cell 0, where F = (cell15 + R1) XOR R2. The mixer then updates R1 = R2 + (R3 XOR cell5), R2 = S1(R1), R3 = S2(R2). The shift register shifts down with new cell 15 = (cell0 << 8) ^ mulA(cell0[31:24]) ^ cell2 ^ (cell11 >> 8) ^ divA(cell11[7:0]).
- R5: A request with count n yields exactly n words on n consecutive cycles; `ks_valid` is never high outside a request.
- R6: `done` is high for exactly one cycle, the cycle of the last valid word (or, for n = 0, 34 edges after acceptance), and the block is idle the cycle after.
- R7: `busy` is high from the cycle after acceptance through the `done` cycle. A start arriving while busy is ignored, even when key, iv and n change with it.
- R8: A count of zero runs the warm-up and the discard step and then signals `done` without any valid word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted only while idle |
| key | input | 128 | Four key words, k0 in the low 32 bits |
| iv | input | 128 | Four IV words, v0 in the low 32 bits |
| n | input | CNT_W | Number of keystream words to emit |
| ks_word | output | 32 | Keystream word |
| ks_valid | output | 1 | `ks_word` holds a new word this cycle |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle end-of-request marker |

## Verification
On every cycle the assertions check the control skeleton. They cover the load of the outermost cells from the key and IV, the zeroed mixer at load, and that the discard step follows exactly the last warm-up round. They also check that valid words stay inside a request and within its count, that `done` is a lone pulse followed by idle, and that a start seen while busy leaves the latched count alone. The keystream values themselves, the 35-edge latency, the exact word count and the ignored restart can only be shown by the bench's runs. Those runs compare the outputs with an independent model over all-zero, all-one, walking-bit and mixed key/IV values.

// File: rtl/ks_pkg.sv
package ks_pkg;

    localparam int WORD_W   = 32;
    localparam int LFSR_LEN = 16;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [7:0]        byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_DISCARD,
        ST_GEN,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        word_t r1;
        word_t r2;
        word_t r3;
    } mix_regs_t;

    localparam byte_t ALPHA_RED = 8'hA9;
    localparam byte_t RIJ_RED   = 8'h1B;
    localparam byte_t DICK_RED  = 8'h69;
    localparam byte_t RIJ_ADD   = 8'h63;
    localparam byte_t DICK_ADD  = 8'h25;

    // multiply by x in GF(2^8) with the given low reduction byte
    function automatic byte_t xtime(byte_t v, byte_t red);
        return v[7] ? ((v << 1) ^ red) : (v << 1);
    endfunction

    function automatic byte_t xtime_pow(byte_t v, int unsigned cnt, byte_t red);
        byte_t acc = v;
        for (int unsigned i = 0; i < cnt; i++) acc = xtime(acc, red);
        return acc;
    endfunction

    function automatic byte_t gf_mul(byte_t a, byte_t b, byte_t red);
        byte_t acc = '0;
        byte_t sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc ^= sh;
            sh = xtime(sh, red);
        end
        return acc;
    endfunction

    function automatic byte_t rotl8(byte_t b, int sh);
        return byte_t'((b << sh) | (b >> (8 - sh)));
    endfunction

    // inverse as x^254, then the affine map
    function automatic byte_t rij_sub(byte_t x);
        byte_t sq  = x;
        byte_t inv = 8'h01;
        for (int i = 1; i < 8; i++) begin
            sq  = gf_mul(sq, sq, RIJ_RED);
            inv = gf_mul(inv, sq, RIJ_RED);
        end
        return inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ RIJ_ADD;
    endfunction

    // Dickson polynomial of degree 49 plus a constant
    function automatic byte_t dick_sub(byte_t x);
        byte_t p2, p4, p8, p9, p13, p15, p16, p32, p33, p41, p45, p47, p49;
        p2  = gf_mul(x,   x,   DICK_RED);
        p4  = gf_mul(p2,  p2,  DICK_RED);
        p8  = gf_mul(p4,  p4,  DICK_RED);
        p9  = gf_mul(p8,  x,   DICK_RED);
        p13 = gf_mul(p9,  p4,  DICK_RED);
        p15 = gf_mul(p13, p2,  DICK_RED);
        p16 = gf_mul(p8,  p8,  DICK_RED);
        p32 = gf_mul(p16, p16, DICK_RED);
        p33 = gf_mul(p32, x,   DICK_RED);
        p41 = gf_mul(p33, p8,  DICK_RED);
        p45 = gf_mul(p41, p4,  DICK_RED);
        p47 = gf_mul(p45, p2,  DICK_RED);
        p49 = gf_mul(p47, p2,  DICK_RED);
        return x ^ p9 ^ p13 ^ p15 ^ p33 ^ p41 ^ p45 ^ p47 ^ p49 ^ DICK_ADD;
    endfunction

    function automatic word_t col_mix(word_t w, byte_t red);
        byte_t b0, b1, b2, b3, m0, m1, m2, m3;
        b0 = w[31:24]; b1 = w[23:16]; b2 = w[15:8]; b3 = w[7:0];
        m0 = xtime(b0, red); m1 = xtime(b1, red);
        m2 = xtime(b2, red); m3 = xtime(b3, red);
        return {m0 ^ b1 ^ b2 ^ m3 ^ b3,
                m0 ^ b0 ^ m1 ^ b2 ^ b3,
                b0 ^ m1 ^ b1 ^ m2 ^ b3,
                b0 ^ b1 ^ m2 ^ b2 ^ m3};
    endfunction

    function automatic word_t box_one(word_t w);
        return col_mix({rij_sub(w[31:24]), rij_sub(w[23:16]),
                        rij_sub(w[15:8]),  rij_sub(w[7:0])}, RIJ_RED);
    endfunction

    function automatic word_t box_two(word_t w);
        return col_mix({dick_sub(w[31:24]), dick_sub(w[23:16]),
                        dick_sub(w[15:8]),  dick_sub(w[7:0])}, DICK_RED);
    endfunction

    function automatic word_t alpha_mul(byte_t c);
        return {xtime_pow(c, 23, ALPHA_RED), xtime_pow(c, 245, ALPHA_RED),
                xtime_pow(c, 48, ALPHA_RED), xtime_pow(c, 239, ALPHA_RED)};
    endfunction

    function automatic word_t alpha_div(byte_t c);
        return {xtime_pow(c, 16, ALPHA_RED), xtime_pow(c, 39, ALPHA_RED),
                xtime_pow(c, 6, ALPHA_RED),  xtime_pow(c, 64, ALPHA_RED)};
    endfunction

endpackage

// File: rtl/ks_lfsr.sv
module ks_lfsr
    import ks_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load,
    input  word_t [LFSR_LEN-1:0]       load_words,
    input  logic                       step,
    input  logic                       init_mode,
    input  word_t                      f_in,
    output word_t                      tap_s0,
    output word_t                      tap_s5,
    output word_t                      tap_s15
);

    word_t [LFSR_LEN-1:0] cells;
    word_t [LFSR_LEN-1:0] nxt;
    word_t                fb;

    always_comb begin
        fb = {cells[0][23:0], 8'h00}
           ^ alpha_mul(cells[0][31:24])
           ^ cells[2]
           ^ {8'h00, cells[11][31:8]}
           ^ alpha_div(cells[11][7:0])
           ^ (init_mode ? f_in : '0);
    end

    for (genvar g = 0; g < LFSR_LEN; g++) begin : g_cell
        if (g == LFSR_LEN - 1) begin : g_top
            assign nxt[g] = fb;
        end else begin : g_mid
            assign nxt[g] = cells[g+1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       cells <= '0;
        else if (load) cells <= load_words;
        else if (step) cells <= nxt;
    end

    assign tap_s0  = cells[0];
    assign tap_s5  = cells[5];
    assign tap_s15 = cells[LFSR_LEN-1];

endmodule

// File: rtl/ks_mix.sv
module ks_mix
    import ks_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  step,
    input  word_t s5,
    input  word_t s15,
    output word_t f
);

    mix_regs_t regs;

    assign f = (s15 + regs.r1) ^ regs.r2;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            regs <= '0;
        end else if (step) begin
            regs.r1 <= regs.r2 + (regs.r3 ^ s5);
            regs.r2 <= box_one(regs.r1);
            regs.r3 <= box_two(regs.r2);
        end
    end

    // R2: a cleared mixer passes the top cell straight through
    p_clear_zero_r2: assert property (@(posedge clk) disable iff (rst)
        clear |=> (f == s15))
        else $error("mixer not cleared at load");

endmodule

// File: rtl/keystream_seq.sv
module keystream_seq
    import ks_pkg::*;
#(
    parameter int INIT_ROUNDS = 32,
    parameter int CNT_W       = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [4*WORD_W-1:0] key,
    input  logic [4*WORD_W-1:0] iv,
    input  logic [CNT_W-1:0]    n,
    output logic [WORD_W-1:0]   ks_word,
    output logic                ks_valid,
    output logic                busy,
    output logic                done
);

    localparam int RND_W = (INIT_ROUNDS > 1) ? $clog2(INIT_ROUNDS) : 1;
    localparam logic [RND_W-1:0] LAST_RND = RND_W'(INIT_ROUNDS - 1);

    seq_state_e           state;
    logic [RND_W-1:0]     rnd;
    logic [CNT_W-1:0]     wcnt;
    logic [CNT_W-1:0]     n_q;
    word_t                kw [4];
    word_t                vw [4];
    word_t [LFSR_LEN-1:0] load_w;
    word_t                s0_w, s5_w, s15_w, f_w;
    logic                 accept, running;

    assign accept  = start && (state == ST_IDLE);
    assign running = (state == ST_INIT) || (state == ST_DISCARD) || (state == ST_GEN);
    assign busy    = (state != ST_IDLE);
    assign done    = (state == ST_DONE);

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            kw[i] = key[WORD_W*i +: WORD_W];
            vw[i] = iv[WORD_W*i +: WORD_W];
        end
        for (int i = 0; i < 4; i++) begin
            load_w[i]      = ~kw[i];
            load_w[4 + i]  =  kw[i];
            load_w[8 + i]  = ~kw[i];
            load_w[12 + i] =  kw[i];
        end
        load_w[15] = load_w[15] ^ vw[0];
        load_w[12] = load_w[12] ^ vw[1];
        load_w[10] = load_w[10] ^ vw[2];
        load_w[9]  = load_w[9]  ^ vw[3];
    end

    ks_lfsr u_lfsr (
        .clk        (clk),
        .rst        (rst),
        .load       (accept),
        .load_words (load_w),
        .step       (running),
        .init_mode  (state == ST_INIT),
        .f_in       (f_w),
        .tap_s0     (s0_w),
        .tap_s5     (s5_w),
        .tap_s15    (s15_w)
    );

    ks_mix u_mix (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .step  (running),
        .s5    (s5_w),
        .s15   (s15_w),
        .f     (f_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            rnd      <= '0;
            wcnt     <= '0;
            n_q      <= '0;
            ks_word  <= '0;
            ks_valid <= 1'b0;
        end else begin
            ks_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        n_q   <= n;
                        rnd   <= '0;
                        state <= ST_INIT;
                    end
                end
                ST_INIT: begin
                    rnd <= rnd + RND_W'(1);
                    if (rnd == LAST_RND) state <= ST_DISCARD;
                end
                ST_DISCARD: begin
                    wcnt  <= '0;
                    state <= (n_q == '0) ? ST_DONE : ST_GEN;
                end
                ST_GEN: begin
                    ks_word  <= f_w ^ s0_w;
                    ks_valid <= 1'b1;
                    wcnt     <= wcnt + CNT_W'(1);
                    if (wcnt == n_q - CNT_W'(1)) state <= ST_DONE;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: outermost cells take the key/IV pattern on acceptance
    p_load_pattern_r2: assert property (@(posedge clk) disable iff (rst)
        accept |=> ((s0_w == ~$past(key[31:0])) &&
                    (s15_w == ($past(key[127:96]) ^ $past(iv[31:0])))))
        else $error("load pattern wrong");

    // R3: discard step directly follows the final warm-up round
    p_init_len_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DISCARD) |-> (($past(state) == ST_INIT) && ($past(rnd) == LAST_RND)))
        else $error("warm-up length wrong");

    // R5: valid words stay inside a request and within its count
    p_valid_in_run_r5: assert property (@(posedge clk) disable iff (rst)
        ks_valid |-> busy)
        else $error("valid outside request");

    p_word_limit_r5: assert property (@(posedge clk) disable iff (rst)
        ks_valid |-> ((wcnt != '0) && (wcnt <= n_q)))
        else $error("too many words");

    // R6: done is a single pulse followed by idle
    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done)
        else $error("done longer than one cycle");

    p_done_then_idle_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy)
        else $error("not idle after done");

    // R7: a request runs to completion and ignores new starts
    p_hold_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy)
        else $error("request dropped");

    p_start_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(n_q))
        else $error("count changed while busy");

endmodule

// File: tb/keystream_seq_test.sv
module keystream_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int MAXW       = 64;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [127:0] key;
    logic [127:0] iv;
    logic [15:0]  n;
    logic [31:0]  ks_word;
    logic         ks_valid;
    logic         busy;
    logic         done;

    int checks = 0;
    int errors = 0;

    bit [31:0] ms [16];
    bit [31:0] mr1, mr2, mr3;
    bit [31:0] exp_w [MAXW];

    always #(CLK_PERIOD/2) clk = ~clk;

    keystream_seq uut (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .key      (key),
        .iv       (iv),
        .n        (n),
        .ks_word  (ks_word),
        .ks_valid (ks_valid),
        .busy     (busy),
        .done     (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // ---------------- independent model ----------------
    function automatic bit [7:0] t_xt(bit [7:0] v, bit [7:0] p);
        return v[7] ? ((v << 1) ^ p) : (v << 1);
    endfunction

    function automatic bit [7:0] t_mul(bit [7:0] a, bit [7:0] b, bit [7:0] p);
        bit [7:0] r = 0;
        bit [7:0] aa = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= aa;
            aa = t_xt(aa, p);
        end
        return r;
    endfunction

    function automatic bit [7:0] t_inv(bit [7:0] x);
        if (x == 0) return 8'h00;
        for (int y = 1; y < 256; y++)
            if (t_mul(x, 8'(y), 8'h1B) == 8'h01) return 8'(y);
        return 8'h00;
    endfunction

    function automatic bit [7:0] t_sr(bit [7:0] x);
        bit [7:0] b = t_inv(x);
        bit [7:0] r = 8'h63 ^ b;
        for (int i = 1; i <= 4; i++) r ^= 8'((b << i) | (b >> (8 - i)));
        return r;
    endfunction

    function automatic bit [7:0] t_sq(bit [7:0] x);
        int e [9] = '{1, 9, 13, 15, 33, 41, 45, 47, 49};
        bit [7:0] acc = 8'h25;
        for (int j = 0; j < 9; j++) begin
            bit [7:0] p = 8'h01;
            for (int k = 0; k < e[j]; k++) p = t_mul(p, x, 8'h69);
            acc ^= p;
        end
        return acc;
    endfunction

    function automatic bit [7:0] t_coef(int r, int c);
        case ((c - r + 4) % 4)
            0: return 8'h02;
            3: return 8'h03;
            default: return 8'h01;
        endcase
    endfunction

    function automatic bit [31:0] t_box(bit [31:0] w, bit sel);
        bit [7:0] b [4];
        bit [7:0] o [4];
        bit [7:0] p = sel ? 8'h69 : 8'h1B;
        for (int i = 0; i < 4; i++) begin
            bit [7:0] raw = w[31 - 8*i -: 8];
            b[i] = sel ? t_sq(raw) : t_sr(raw);
        end
        for (int r = 0; r < 4; r++) begin
            o[r] = 0;
            for (int c = 0; c < 4; c++) o[r] ^= t_mul(b[c], t_coef(r, c), p);
        end
        return {o[0], o[1], o[2], o[3]};
    endfunction

    function automatic bit [7:0] t_pow(bit [7:0] v, int k);
        bit [7:0] r = v;
        for (int i = 0; i < k; i++) r = t_xt(r, 8'hA9);
        return r;
    endfunction

    task automatic m_fsm(output bit [31:0] f);
        bit [31:0] r;
        f   = (ms[15] + mr1) ^ mr2;
        r   = mr2 + (mr3 ^ ms[5]);
        mr3 = t_box(mr2, 1'b1);
        mr2 = t_box(mr1, 1'b0);
        mr1 = r;
    endtask

    task automatic m_lfsr(input bit use_f, input bit [31:0] f);
        bit [31:0] v;
        bit [7:0]  hi = ms[0][31:24];
        bit [7:0]  lo = ms[11][7:0];
        v = (ms[0] << 8) ^ (ms[11] >> 8) ^ ms[2]
          ^ {t_pow(hi, 23), t_pow(hi, 245), t_pow(hi, 48), t_pow(hi, 239)}
          ^ {t_pow(lo, 16), t_pow(lo, 39), t_pow(lo, 6), t_pow(lo, 64)};
        if (use_f) v ^= f;
        for (int i = 0; i < 15; i++) ms[i] = ms[i+1];
        ms[15] = v;
    endtask

    task automatic m_build(input bit [127:0] k, input bit [127:0] v, input int nw);
        bit [31:0] kk [4];
        bit [31:0] vv [4];
        bit [31:0] f;
        for (int i = 0; i < 4; i++) begin
            kk[i] = k[32*i +: 32];
            vv[i] = v[32*i +: 32];
        end
        ms[15] = kk[3] ^ vv[0]; ms[14] = kk[2]; ms[13] = kk[1]; ms[12] = kk[0] ^ vv[1];
        ms[11] = ~kk[3]; ms[10] = ~kk[2] ^ vv[2]; ms[9] = ~kk[1] ^ vv[3]; ms[8] = ~kk[0];
        ms[7] = kk[3]; ms[6] = kk[2]; ms[5] = kk[1]; ms[4] = kk[0];
        ms[3] = ~kk[3]; ms[2] = ~kk[2]; ms[1] = ~kk[1]; ms[0] = ~kk[0];
        mr1 = 0; mr2 = 0; mr3 = 0;
        for (int r = 0; r < 32; r++) begin
            m_fsm(f);
            m_lfsr(1'b1, f);
        end
        m_fsm(f);
        m_lfsr(1'b0, 32'h0);
        for (int t = 0; t < nw; t++) begin
            m_fsm(f);
            exp_w[t] = f ^ ms[0];
            m_lfsr(1'b0, 32'h0);
        end
    endtask

    // ---------------- one request ----------------
    task automatic run_case(input bit [127:0] k, input bit [127:0] v,
                            input int nw, input bit poke);
        int  cyc  = 1;
        int  widx = 0;
        bit  seen = 0;
        m_build(k, v, nw);
        @(negedge clk);
        key = k; iv = v; n = 16'(nw); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R7", "busy after accept", 32'(busy), 32'd1);
        while (!seen && cyc < 400) begin
            if (ks_valid) begin
                if (widx < nw) begin
                    check(ks_word == exp_w[widx], "R4", "keystream word", ks_word, exp_w[widx]);
                    if (widx == 0)
                        check(cyc == 35, "R3", "first word latency", 32'(cyc), 32'd35);
                    else
                        check(cyc == 35 + widx, "R5", "consecutive word", 32'(cyc), 32'(35 + widx));
                end else begin
                    check(1'b0, "R5", "extra word", 32'(widx), 32'(nw));
                end
                widx++;
            end
            if (done) begin
                check(cyc == 34 + nw, "R6", "done timing", 32'(cyc), 32'(34 + nw));
                check(widx == nw, "R5", "word count", 32'(widx), 32'(nw));
                if (nw == 0)
                    check(widx == 0, "R8", "no words for zero count", 32'(widx), 32'd0);
                seen = 1;
            end
            if (poke && cyc == 8) begin
                start = 1'b1; key = ~k; iv = ~v; n = 16'(nw + 3);
            end
            if (poke && cyc == 9) start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        if (!seen) check(1'b0, "R6", "done never raised", 32'(cyc), 32'(34 + nw));
        check(!busy && !done && !ks_valid, "R6", "idle after done",
              {29'd0, busy, done, ks_valid}, 32'd0);
        if (poke) check(busy == 1'b0, "R7", "restart while busy ignored", 32'(busy), 32'd0);
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R6", "watchdog expired", 32'd0, 32'd1);
        report();
    end

    initial begin
        rst = 1'b1; start = 1'b0; key = '0; iv = '0; n = '0;
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1", "busy at reset", 32'(busy), 32'd0);
        check(done == 1'b0, "R1", "done at reset", 32'(done), 32'd0);
        check(ks_valid == 1'b0, "R1", "valid at reset", 32'(ks_valid), 32'd0);
        check(ks_word == 32'd0, "R1", "word at reset", ks_word, 32'd0);
        rst = 1'b0;

        // R2 R4: extreme key/IV values
        run_case('0, '0, 4, 1'b0);
        run_case('1, '1, 4, 1'b0);
        run_case('1, '0, 3, 1'b0);
        // R7: restart attempt mid-request
        run_case(128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0,
                 128'h01234567_89abcdef_fedcba98_76543210, 8, 1'b1);
        // R5: single word; R8: zero words
        run_case(128'hdeadbeef_00000001_80000000_12345678, 128'h5a5a5a5a_a5a5a5a5_0, 1, 1'b0);
        run_case(128'hcafef00d_0, 128'h1, 0, 1'b0);
        // R2: walking key bits and IV bits, one per word lane
        for (int b = 0; b < 8; b++)
            run_case(128'h1 << (b * 16 + 3), '0, 2, 1'b0);
        for (int b = 0; b < 4; b++)
            run_case('0, 128'h80000000 << (b * 32), 2, 1'b0);
        report();
    end

endmodule